// File: doc/BRIEF.md
# Delayed-Phase SPI Master Serial Clock and Shifter

This block is the timing core of a serial-peripheral master that launches each outgoing bit half a serial-clock period ahead of the edge at which both ends sample. A 7-bit baud code sets the divide ratio from the local clock. A polarity input selects the level at which the serial clock idles. A start strobe loads an 8-bit word, which is then shifted out most-significant bit first on the master-out line, while eight bits are gathered from the master-in line.

When the word ends the serial clock sits at its idle level and busy drops. The gathered word is presented with a one-cycle ready pulse. Baud code and polarity are taken in with the start strobe and hold for the whole word. A start strobe that arrives while a word is in flight is dropped.

Top module: `spi_dly_master`

## Requirements
- R1: After synchronous active-low reset, sclk, mosi, busy and rx_ready are 0 and rx_word is 0.
- R2: For a baud code of 3 or more, the serial clock period is (baud code + 1) local clock cycles.
- R3: Baud codes 0, 1 and 2 give a serial clock period of 4 local clock cycles, the same as code 3.
- R4: Each bit period of N cycles first holds sclk at its idle level for N - floor(N/2) cycles and then at the opposite level for floor(N/2) cycles. With an odd N, the high phase is therefore the shorter one for polarity 0 and the low phase the shorter one for polarity 1.
- R5: sclk idles at the captured polarity (low for 0, high for 1). The referenced edge is the transition away from idle: rising for polarity 0 and falling for polarity 1. While idle, sclk does not move.
- R6: mosi carries tx_word MSB first. The first bit appears on the clock edge that accepts start. Each later bit appears when sclk returns to idle, so each bit leads its referenced edge by N - floor(N/2) cycles and is held floor(N/2) cycles after it.
- R7: miso is sampled at the clock edge on which sclk makes its referenced transition. The first sample becomes bit 7 of rx_word.
- R8: busy rises on the edge that accepts start and stays high for exactly 8*N cycles. On the edge it falls, rx_ready pulses high for one cycle and rx_word holds the received word.
- R9: A start strobe while busy is high has no effect on the word in flight.
- R10: Changes on baud_code or cpol while busy have no effect until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_code | input | 7 | Divide code, captured at start |
| cpol | input | 1 | Clock polarity, captured at start |
| start | input | 1 | Begin a word when not busy |
| tx_word | input | 8 | Word to transmit, loaded at start |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| busy | output | 1 | A word is being shifted |
| rx_ready | output | 1 | One-cycle pulse when rx_word is new |
| rx_word | output | 8 | Last received word |

## Verification
Words are run with even ratios (8 and 128), with odd ratios (5 and 11) under both polarities, and with the three low codes that must collapse to a ratio of four. The even cases check the basic divide. The odd cases show whether the longer phase is kept at the idle level, which is the only thing that separates a correct polarity swap from a plain inverted clock. The slave word differs from the transmit word, so a swap of the shift directions or a sample taken at the wrong edge shows up as a wrong received word. One word has baud, polarity and start changed in mid-flight, and two words run back to back. Together these show whether capture-at-start holds and whether a start landing on the final edge is ignored.

// File: rtl/spi_dly_pkg.sv
// Shared constants and types for the delayed-phase SPI master.
// Assumes: one local clock domain, word length fixed at elaboration.
package spi_dly_pkg;

    localparam int WORD_W_DEF    = 8;  // bits per word
    localparam int BAUD_W_DEF    = 7;  // width of the baud code
    localparam int MIN_CODE_DEF  = 3;  // codes below this collapse to the floor ratio
    localparam int FLOOR_RATIO   = 4;  // ratio used for the collapsed codes

    typedef enum logic {
        XFER_IDLE = 1'b0,
        XFER_RUN  = 1'b1
    } xfer_state_t;

endpackage

// File: rtl/spi_dly_baudgen.sv
// Baud divider: holds the captured baud code and walks a per-bit cycle
// counter. It marks the cycle before the referenced edge (ref_tick) and the
// cycle before the bit ends (end_tick).
// Assumes: load is only asserted while run is low; ratio is at least 4.
module spi_dly_baudgen #(
    parameter int BAUD_W = spi_dly_pkg::BAUD_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BAUD_W-1:0] baud_in,
    input  logic              run,
    output logic [BAUD_W-1:0] baud_q,
    output logic              ref_tick,
    output logic              end_tick
);
    localparam int CNT_W = BAUD_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] ratio;
    logic [CNT_W-1:0] lead_len;

    // Divide ratio and length of the idle-level (leading) phase.
    always_comb begin
        if (baud_q < BAUD_W'(spi_dly_pkg::MIN_CODE_DEF))
            ratio = CNT_W'(spi_dly_pkg::FLOOR_RATIO);
        else
            ratio = {1'b0, baud_q} + CNT_W'(1);
        lead_len = ratio - (ratio >> 1);
    end

    assign ref_tick = run && (cnt == lead_len - CNT_W'(1));
    assign end_tick = run && (cnt == ratio - CNT_W'(1));

    // Capture the baud code when a word is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            baud_q <= '0;
        else if (load)
            baud_q <= baud_in;
    end

    // Per-bit cycle counter, restarted at load and at every bit end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load || end_tick)
            cnt <= '0;
        else if (run)
            cnt <= cnt + CNT_W'(1);
    end

endmodule

// File: rtl/spi_dly_bitcnt.sv
// Bit counter: counts completed bit periods within a word and flags the
// final one.
// Assumes: WORD_W is at least 2.
module spi_dly_bitcnt #(
    parameter int WORD_W = spi_dly_pkg::WORD_W_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic end_tick,
    output logic last_bit
);
    localparam int BIT_W = $clog2(WORD_W);

    logic [BIT_W-1:0] bit_idx;

    assign last_bit = (bit_idx == BIT_W'(WORD_W - 1));

    // Advance the bit index at each bit end, restart on load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bit_idx <= '0;
        else if (load)
            bit_idx <= '0;
        else if (end_tick)
            bit_idx <= last_bit ? '0 : bit_idx + BIT_W'(1);
    end

endmodule

// File: rtl/spi_dly_shifter.sv
// Shift datapath: an MSB-first transmit register driving mosi, a receive
// register filled at referenced edges, and the output holding register.
// Assumes: sample and advance never coincide (phases are at least 2 cycles).
module spi_dly_shifter #(
    parameter int WORD_W = spi_dly_pkg::WORD_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] tx_in,
    input  logic              advance,
    input  logic              sample,
    input  logic              miso,
    input  logic              capture,
    output logic              mosi,
    output logic [WORD_W-1:0] rx_out
);
    logic [WORD_W-1:0] tx_sh;
    logic [WORD_W-1:0] rx_sh;

    assign mosi = tx_sh[WORD_W-1];

    // Load the transmit word, then shift it left at each bit boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_sh <= '0;
        else if (load)
            tx_sh <= tx_in;
        else if (advance)
            tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
    end

    // Gather miso at each referenced edge, first bit ending up as MSB.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_sh <= '0;
        else if (sample)
            rx_sh <= {rx_sh[WORD_W-2:0], miso};
    end

    // Present the finished word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_out <= '0;
        else if (capture)
            rx_out <= rx_sh;
    end

endmodule

// File: rtl/spi_dly_master.sv
// Delayed-phase SPI master: sequences one word per accepted start, drives
// the serial clock from the baud divider strobes and the captured polarity.
// Assumes: miso is synchronous to clk or already synchronised upstream.
module spi_dly_master #(
    parameter int WORD_W = spi_dly_pkg::WORD_W_DEF,
    parameter int BAUD_W = spi_dly_pkg::BAUD_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BAUD_W-1:0] baud_code,
    input  logic              cpol,
    input  logic              start,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              busy,
    output logic              rx_ready,
    output logic [WORD_W-1:0] rx_word
);
    import spi_dly_pkg::*;

    xfer_state_t       state;
    logic              accept;
    logic              finish;
    logic              ref_tick;
    logic              end_tick;
    logic              last_bit;
    logic              pol_q;
    logic [BAUD_W-1:0] baud_q;

    assign busy   = (state == XFER_RUN);
    assign accept = start && !busy;
    assign finish = end_tick && last_bit;

    spi_dly_baudgen #(.BAUD_W(BAUD_W)) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .baud_in  (baud_code),
        .run      (busy),
        .baud_q   (baud_q),
        .ref_tick (ref_tick),
        .end_tick (end_tick)
    );

    spi_dly_bitcnt #(.WORD_W(WORD_W)) u_bits (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .end_tick (end_tick),
        .last_bit (last_bit)
    );

    spi_dly_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .tx_in   (tx_word),
        .advance (end_tick && !last_bit),
        .sample  (ref_tick),
        .miso    (miso),
        .capture (finish),
        .mosi    (mosi),
        .rx_out  (rx_word)
    );

    // Word sequencer: idle until accepted start, run until the last bit ends.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= XFER_IDLE;
        else if (accept)
            state <= XFER_RUN;
        else if (finish)
            state <= XFER_IDLE;
    end

    // Capture the polarity with the word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pol_q <= 1'b0;
        else if (accept)
            pol_q <= cpol;
    end

    // Serial clock: idle level at start and bit ends, opposite after the referenced edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sclk <= 1'b0;
        else if (accept)
            sclk <= cpol;
        else if (ref_tick)
            sclk <= !pol_q;
        else if (end_tick)
            sclk <= pol_q;
    end

    // Ready pulse for one cycle after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_ready <= 1'b0;
        else
            rx_ready <= finish;
    end

endmodule

// File: rtl/spi_dly_master_chk.sv
// Property checker for the delayed-phase SPI master, bound to the top.
// Assumes: observes ports and a few internal sequencing signals.
module spi_dly_master_chk #(
    parameter int BAUD_W = spi_dly_pkg::BAUD_W_DEF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              rx_ready,
    input logic              sclk,
    input logic              mosi,
    input logic              pol_q,
    input logic              finish,
    input logic [BAUD_W-1:0] baud_q
);

    // R5
    idle_sclk_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> (busy || $stable(sclk)));

    // R6
    mosi_moves_at_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$stable(mosi)) |-> (sclk == pol_q));

    // R6
    mosi_held_over_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$stable(sclk) && (sclk != pol_q)) |-> $stable(mosi));

    // R8
    ready_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> (!busy && $past(busy)));

    // R8
    finish_gives_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> (rx_ready && !busy && (sclk == pol_q)));

    // R9
    start_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !finish) |=> busy);

    // R10
    baud_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(baud_q) && $stable(pol_q)));

endmodule

bind spi_dly_master spi_dly_master_chk #(.BAUD_W(BAUD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .rx_ready (rx_ready),
    .sclk     (sclk),
    .mosi     (mosi),
    .pol_q    (pol_q),
    .finish   (finish),
    .baud_q   (baud_q)
);

// File: tb/sim_spi_dly_master.sv
module sim_spi_dly_master;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] baud_code = '0;
    logic       cpol = 1'b0;
    logic       start = 1'b0;
    logic [7:0] tx_word = '0;
    logic       miso = 1'b0;
    logic       sclk, mosi, busy, rx_ready;
    logic [7:0] rx_word;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done_run = 0;

    always #2.5 clk = ~clk;

    spi_dly_master u0 (
        .clk(clk), .rst_n(rst_n), .baud_code(baud_code), .cpol(cpol),
        .start(start), .tx_word(tx_word), .miso(miso), .sclk(sclk),
        .mosi(mosi), .busy(busy), .rx_ready(rx_ready), .rx_word(rx_word)
    );

    // Behavioural reference: elapsed cycles since the accepting edge.
    bit       m_act = 0, m_busy = 0, m_done = 0, m_sclk = 0, m_mosi = 0, m_pol = 0;
    int       m_e = 0, m_n = 4, m_h1 = 2;
    bit [7:0] m_tx = 0, m_acc = 0, m_rx = 0;
    bit [7:0] slv = 0;

    function automatic int ratio_of(input int code);
        return (code < 3) ? 4 : code + 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0; m_busy = 0; m_done = 0; m_sclk = 0; m_mosi = 0;
            m_rx = 0; m_pol = 0;
        end else begin
            m_done = 0;
            if (m_act) begin
                m_e = m_e + 1;
                if (m_e % m_n == m_h1) m_acc[7 - m_e / m_n] = miso;
                if (m_e == 8 * m_n) begin
                    m_act = 0; m_busy = 0; m_done = 1; m_rx = m_acc; m_sclk = m_pol;
                end else begin
                    m_sclk = (m_e % m_n >= m_h1) ? !m_pol : m_pol;
                    m_mosi = m_tx[7 - m_e / m_n];
                end
            end else if (start) begin
                m_n = ratio_of(int'(baud_code));
                m_h1 = m_n - m_n / 2;
                m_pol = cpol; m_tx = tx_word; m_acc = 0;
                m_e = 0; m_act = 1; m_busy = 1; m_sclk = cpol; m_mosi = tx_word[7];
            end
        end
    end

    // Slave side: one bit of slv per bit period.
    always @(negedge clk) begin
        if (m_act) miso <= slv[7 - m_e / m_n];
        else miso <= 1'b0;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Cycle compare against the reference.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done_run) begin
            check("R4 R5 sclk", sclk, m_sclk);
            check("R6 mosi", mosi, m_mosi);
            check("R8 busy", busy, m_busy);
            check("R8 rx_ready", rx_ready, m_done);
            if (m_done) check("R7 rx_word", rx_word, m_rx);
        end
        if (cyc > 150000 && !done_run) begin
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Run one word; optionally disturb inputs mid-word (R9 R10).
    task automatic run_word(input int code, input bit pol, input bit [7:0] tx,
                            input bit [7:0] sw, input bit disturb);
        int n, h1, nb, nidle, nact, guard;
        n = ratio_of(code);
        h1 = n - n / 2;
        nb = 0; nidle = 0; nact = 0; guard = 0;
        @(negedge clk);
        baud_code = 7'(code); cpol = pol; tx_word = tx; slv = sw; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!rx_ready && guard < 3000) begin
            if (busy) begin
                nb++;
                if (sclk == pol) nidle++; else nact++;
            end
            if (disturb && guard == 3) begin
                baud_code = ~7'(code); cpol = !pol; start = 1'b1; tx_word = ~tx;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            guard++;
        end
        start = 1'b0;
        check("R7 received word", rx_word, sw);
        check("R8 busy length", nb, 8 * n);
        check("R2 R3 R4 idle-level cycles", nidle, 8 * h1);
        check("R2 R3 R4 active-level cycles", nact, 8 * (n / 2));
        @(negedge clk);
        check("R8 ready single pulse", rx_ready, 0);
        check("R5 idle level after word", sclk, pol);
        check("R9 R10 busy low after word", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 sclk", sclk, 0);
        check("R1 mosi", mosi, 0);
        check("R1 busy", busy, 0);
        check("R1 rx_ready", rx_ready, 0);
        check("R1 rx_word", rx_word, 0);
        rst_n = 1'b1;
        run_word(7, 1'b0, 8'hA5, 8'h3C, 1'b0);    // R2 even ratio
        run_word(4, 1'b0, 8'h81, 8'hE7, 1'b0);    // R4 odd, polarity 0
        run_word(4, 1'b1, 8'h5A, 8'h96, 1'b0);    // R4 odd, polarity 1
        run_word(0, 1'b0, 8'hF0, 8'h0F, 1'b0);    // R3
        run_word(1, 1'b1, 8'hC3, 8'h71, 1'b0);    // R3
        run_word(2, 1'b0, 8'h12, 8'hED, 1'b0);    // R3
        run_word(3, 1'b1, 8'h7E, 8'hB4, 1'b0);    // R2 lowest direct code
        run_word(10, 1'b1, 8'h69, 8'h2D, 1'b1);   // R9 R10 disturbed
        run_word(127, 1'b1, 8'hB2, 8'hC9, 1'b0);  // R2 longest period
        // back-to-back: start held through the final edge (R9)
        @(negedge clk);
        baud_code = 7'd5; cpol = 1'b0; tx_word = 8'h4D; slv = 8'hA1; start = 1'b1;
        repeat (8 * 6 + 1) @(negedge clk);
        check("R9 start ignored on final edge", busy, 0);
        @(negedge clk);
        start = 1'b0;
        check("R8 next word accepted", busy, 1);
        while (busy) @(negedge clk);
        check("R7 back-to-back word", rx_word, 8'hA1);
        repeat (4) @(negedge clk);
        done_run = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule